// File: doc/BRIEF.md
# Turbo Extrinsic Memory Phase Controller

This block owns the extrinsic-information store of a serial Turbo decoder built around a single, time-shared soft-in soft-out (SISO) engine. Every decoding iteration is split into two passes over the block: a sequential pass that visits the information bits in natural order, and an interleaved pass that visits them through a permutation table held inside the controller. For each bit the controller reads the stored a priori value, hands it to the SISO engine together with the bit index and pass flag, and later stores the returned extrinsic value back at the very address it was read from. Because results always go home to their own address, no inverse permutation is ever needed.

The store is a single-port memory. Each bit therefore costs two cycles: a read slot and a write slot, and the SISO engine is expected to answer exactly `LAT` cycles (an even number) after each request, so that every answer lands in a write slot. The controller tracks outstanding answers with a delay line that carries each read address forward to become the write address. Before a new pass begins, every answer of the previous pass has been written, so a pass always sees the complete output of the one before it.

A job is launched with a block length, an iteration count and a start pulse. The store is first zeroed over the block, the passes run, and a one-cycle completion pulse marks the end. The permutation table is filled through its own write port while the controller is idle.

Top module: `turbo_ext_seq`

## Requirements
- R1: After reset, `done` and `siso_req` are low and stay low until a job is started.
- R2: On `start` in idle, addresses 0..N-1 (N = `blk_len`, 1..2^ADDR_W) are set to zero, so every request of the first sequential pass carries `siso_apri` = 0.
- R3: Each iteration issues N requests with `siso_phase` = 0 and then N requests with `siso_phase` = 1; within a pass `siso_idx` runs 0, 1, ..., N-1, and a job issues exactly 2·N·`iter_num` requests.
- R4: In a pass with `siso_phase` = 0 the request for index k reads address k.
- R5: In a pass with `siso_phase` = 1 the request for index k reads address T[k], where T[k] is the value last written to table entry k through `tbl_we`/`tbl_idx`/`tbl_val`.
- R6: The `siso_ext` value presented with `siso_vld` exactly LAT cycles after a request is stored at the address that request read, and every later request (same job, any pass or iteration) reads the newest stored value of its address.
- R7: The memory is never read and written in the same cycle; two requests are never on consecutive cycles, and requests for index k and k+1 of one pass are exactly 2 cycles apart.
- R8: `done` is a one-cycle pulse raised only after the last write of the last iteration; with `iter_num` = 0 the store is cleared and `done` pulses with no request issued.
- R9: While a job is running, `start` and table writes are ignored: the running job keeps its length, count and permutation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a job when idle |
| blk_len | input | ADDR_W+1 | Block length N, 1..2^ADDR_W |
| iter_num | input | ITER_W | Number of iterations |
| tbl_we | input | 1 | Permutation table write strobe (idle only) |
| tbl_idx | input | ADDR_W | Table entry written |
| tbl_val | input | ADDR_W | Permuted address stored in the entry |
| siso_req | output | 1 | A priori value and index are valid this cycle |
| siso_idx | output | ADDR_W | Position k within the current pass |
| siso_phase | output | 1 | 0 sequential pass, 1 interleaved pass |
| siso_apri | output | DATA_W | A priori value read from the store |
| siso_vld | input | 1 | SISO answer valid, LAT cycles after its request |
| siso_ext | input | DATA_W | New extrinsic value |
| done | output | 1 | One-cycle job completion pulse |

## Verification
With `start` sampled at an edge, the store is cleared over the next N cycles and the first request appears in the cycle after that; requests then come every second cycle, each answer is due LAT cycles after its request, and `done` follows the last write by one cycle plus the pass hand-over. The bench models the SISO engine as a LAT-stage pipeline sampled at the falling edge, so each answer is driven in exactly the cycle the controller expects it, and computes every expected a priori value from its own copy of the store. A scoreboard queue filled before each job is popped on every request, so checks follow the design's cadence rather than fixed cycle numbers, while the 2-cycle spacing and the completion pulse are checked against a cycle counter.

// File: rtl/ext_ctrl_pkg.sv
// Package: shared types of the extrinsic memory phase controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package ext_ctrl_pkg;

    // Controller sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } ctrl_st_e;

endpackage

// File: rtl/ext_spram.sv
// Module: single-port extrinsic store with a registered read port.
// Assumes at most one of write or read per cycle; a write wins if both
// are raised. Contents are not reset: the controller clears them.
module ext_spram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Single shared port: write or registered read.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end else if (re) begin
            rdata <= mem_q[addr];
        end
    end
endmodule

// File: rtl/perm_table.sv
// Module: interleaver permutation table, one write port, one
// combinational read port. Assumes writes are only enabled by the owner
// when the table is not in use.
module perm_table #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] widx,
    input  logic [ADDR_W-1:0] wval,
    input  logic [ADDR_W-1:0] ridx,
    output logic [ADDR_W-1:0] rval
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] tbl_q [DEPTH];

    // Store one permutation entry.
    always_ff @(posedge clk) begin
        if (we) begin
            tbl_q[widx] <= wval;
        end
    end

    // Look up the permuted address for the current position.
    assign rval = tbl_q[ridx];
endmodule

// File: rtl/addr_delay.sv
// Module: DEPTH-stage valid/address delay line. It turns the address of
// each request into the write address of its answer DEPTH cycles later.
// Assumes DEPTH >= 1. busy is high while any stage holds a valid entry.
module addr_delay #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d,
    output logic         busy
);
    logic [DEPTH-1:0] v_q;
    logic [W-1:0]     d_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            // First stage takes the fresh request.
            always_ff @(posedge clk) begin
                if (!rst_n) v_q[i] <= 1'b0;
                else        v_q[i] <= in_v;
                d_q[i] <= in_d;
            end
        end else begin : g_body
            // Later stages shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) v_q[i] <= 1'b0;
                else        v_q[i] <= v_q[i-1];
                d_q[i] <= d_q[i-1];
            end
        end
    end

    assign out_v = v_q[DEPTH-1];
    assign out_d = d_q[DEPTH-1];
    assign busy  = |v_q;
endmodule

// File: rtl/turbo_ext_seq.sv
// Module: extrinsic memory phase controller for a serial Turbo decoder.
// Runs iter_num iterations, each a sequential pass then an interleaved
// pass, over a single-port store with one read slot and one write slot
// per bit, writing each answer back to the address it was read from.
// Assumes: LAT is even and >= 2 (answers fall in write slots), the SISO
// answers every request exactly LAT cycles later, 1 <= blk_len <= 2^ADDR_W,
// and table entries 0..N-1 hold a permutation of 0..N-1.
module turbo_ext_seq
    import ext_ctrl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int ITER_W = 3,
    parameter int LAT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W:0]   blk_len,
    input  logic [ITER_W-1:0] iter_num,
    input  logic              tbl_we,
    input  logic [ADDR_W-1:0] tbl_idx,
    input  logic [ADDR_W-1:0] tbl_val,
    output logic              siso_req,
    output logic [ADDR_W-1:0] siso_idx,
    output logic              siso_phase,
    output logic [DATA_W-1:0] siso_apri,
    input  logic              siso_vld,
    input  logic [DATA_W-1:0] siso_ext,
    output logic              done
);
    localparam int CNT_W = ADDR_W + 1;

    ctrl_st_e          st_q;
    logic [CNT_W-1:0]  n_q;
    logic [CNT_W-1:0]  k_q;
    logic [ITER_W-1:0] iters_q;
    logic [ITER_W-1:0] iter_q;
    logic              phase_q;
    logic              slot_q;
    logic [ADDR_W-1:0] clr_q;
    logic              done_q;

    logic              rd_v_q;
    logic [ADDR_W-1:0] rd_idx_q;
    logic [ADDR_W-1:0] rd_addr_q;

    logic              rd_en;
    logic [ADDR_W-1:0] perm_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              clearing;
    logic              last_clr;
    logic              tbl_we_ok;
    logic              wr_v;
    logic [ADDR_W-1:0] wr_addr;
    logic              dly_busy;
    logic              mem_we;
    logic              mem_re;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    // Read slot: even slot of a run pass while positions remain.
    assign rd_en     = (st_q == ST_RUN) && !slot_q && (k_q != n_q);
    assign rd_addr   = phase_q ? perm_addr : k_q[ADDR_W-1:0];
    assign clearing  = (st_q == ST_CLEAR);
    assign last_clr  = ({1'b0, clr_q} == (n_q - CNT_W'(1)));
    assign tbl_we_ok = tbl_we && (st_q == ST_IDLE);

    // Port arbitration for the single-port store.
    assign mem_we    = clearing || (siso_vld && wr_v);
    assign mem_re    = rd_en;
    assign mem_addr  = clearing ? clr_q : (mem_we ? wr_addr : rd_addr);
    assign mem_wdata = clearing ? '0 : siso_ext;

    perm_table #(.ADDR_W(ADDR_W)) u_tbl (
        .clk  (clk),
        .we   (tbl_we_ok),
        .widx (tbl_idx),
        .wval (tbl_val),
        .ridx (k_q[ADDR_W-1:0]),
        .rval (perm_addr)
    );

    ext_spram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    addr_delay #(.W(ADDR_W), .DEPTH(LAT)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (rd_v_q),
        .in_d  (rd_addr_q),
        .out_v (wr_v),
        .out_d (wr_addr),
        .busy  (dly_busy)
    );

    // Main sequencer: clear, run passes, drain, hand over, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            n_q     <= '0;
            k_q     <= '0;
            iters_q <= '0;
            iter_q  <= '0;
            phase_q <= 1'b0;
            slot_q  <= 1'b0;
            clr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        n_q     <= blk_len;
                        iters_q <= iter_num;
                        clr_q   <= '0;
                        st_q    <= ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    clr_q <= clr_q + ADDR_W'(1);
                    if (last_clr) begin
                        iter_q  <= '0;
                        phase_q <= 1'b0;
                        k_q     <= '0;
                        slot_q  <= 1'b0;
                        if (iters_q == '0) begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            st_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    slot_q <= ~slot_q;
                    if (rd_en) k_q <= k_q + CNT_W'(1);
                    if (k_q == n_q) st_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (!rd_v_q && !dly_busy) begin
                        k_q    <= '0;
                        slot_q <= 1'b0;
                        if (!phase_q) begin
                            phase_q <= 1'b1;
                            st_q    <= ST_RUN;
                        end else if (iter_q == iters_q - ITER_W'(1)) begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            iter_q  <= iter_q + ITER_W'(1);
                            phase_q <= 1'b0;
                            st_q    <= ST_RUN;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Request stage: remember what the read slot fetched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v_q <= 1'b0;
        end else begin
            rd_v_q <= rd_en;
        end
        if (rd_en) begin
            rd_idx_q  <= k_q[ADDR_W-1:0];
            rd_addr_q <= rd_addr;
        end
    end

    assign siso_req   = rd_v_q;
    assign siso_idx   = rd_idx_q;
    assign siso_phase = phase_q;
    assign siso_apri  = mem_rdata;
    assign done       = done_q;
endmodule

// File: rtl/ext_seq_chk.sv
// Module: protocol checker for turbo_ext_seq, attached with bind.
// Assumes it sees the top's ports and its store/delay-line controls.
module ext_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic siso_req,
    input logic siso_vld,
    input logic done,
    input logic mem_we,
    input logic mem_re,
    input logic wr_v,
    input logic rd_v_q,
    input logic dly_busy
);
    // R7
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R7
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        siso_req |=> !siso_req);

    // R6
    resp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        siso_vld |-> wr_v);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!dly_busy && !rd_v_q && !siso_req));
endmodule

bind turbo_ext_seq ext_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .siso_req (siso_req),
    .siso_vld (siso_vld),
    .done     (done),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .wr_v     (wr_v),
    .rd_v_q   (rd_v_q),
    .dly_busy (dly_busy)
);

// File: tb/tb_turbo_ext_seq.sv
`timescale 1ns/1ps
module tb_turbo_ext_seq;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int ITER_W = 3;
    localparam int LAT    = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W:0]   blk_len = '0;
    logic [ITER_W-1:0] iter_num = '0;
    logic              tbl_we = 1'b0;
    logic [ADDR_W-1:0] tbl_idx = '0;
    logic [ADDR_W-1:0] tbl_val = '0;
    logic              siso_req;
    logic [ADDR_W-1:0] siso_idx;
    logic              siso_phase;
    logic [DATA_W-1:0] siso_apri;
    logic              siso_vld = 1'b0;
    logic [DATA_W-1:0] siso_ext = '0;
    logic              done;

    turbo_ext_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ITER_W(ITER_W), .LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
        .iter_num(iter_num), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_val(tbl_val), .siso_req(siso_req), .siso_idx(siso_idx),
        .siso_phase(siso_phase), .siso_apri(siso_apri), .siso_vld(siso_vld),
        .siso_ext(siso_ext), .done(done)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int idx;
        int ph;
        int apri;
        int tag;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          req_cnt = 0;
    int          done_cnt = 0;
    logic [7:0]  model [DEPTH];
    int          perm_m [DEPTH];
    logic        pv [LAT+1];
    logic [7:0]  pd [LAT+1];
    int          prev_cyc = -10;
    int          prev_idx = -10;
    int          prev_ph = -1;
    logic        prev_done = 1'b0;

    function automatic string tag_of(int t);
        case (t)
            2: return "R2";
            4: return "R4";
            5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
        end
    endtask

    // SISO model, scoreboard monitor and done monitor, all at the falling edge.
    always @(negedge clk) begin
        cyc++;
        for (int i = LAT; i > 0; i--) begin
            pv[i] = pv[i-1];
            pd[i] = pd[i-1];
        end
        pv[0] = rst_n && siso_req;
        pd[0] = siso_apri + 8'(siso_idx) + 8'd1;
        siso_vld <= pv[LAT];
        siso_ext <= pd[LAT];
        if (rst_n && siso_req) begin
            req_cnt++;
            if (q.size() == 0) begin
                chk(1'b0, "R3 unexpected request", int'(siso_idx), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(int'(siso_idx) == e.idx, "R3 index", int'(siso_idx), e.idx);
                chk(int'(siso_phase) == e.ph, "R3 pass", int'(siso_phase), e.ph);
                chk(int'(siso_apri) == e.apri, tag_of(e.tag), int'(siso_apri), e.apri);
            end
            if (int'(siso_phase) == prev_ph && int'(siso_idx) == prev_idx + 1)
                chk(cyc - prev_cyc == 2, "R7 spacing", cyc - prev_cyc, 2);
            prev_cyc = cyc;
            prev_idx = int'(siso_idx);
            prev_ph  = int'(siso_phase);
        end
        if (rst_n && done) begin
            done_cnt++;
            chk(!prev_done, "R8 pulse width", 2, 1);
            chk(q.size() == 0, "R8 early done", q.size(), 0);
            begin
                int pend = 0;
                for (int i = 0; i <= LAT; i++) if (pv[i]) pend++;
                chk(pend == 0, "R8 pending answers", pend, 0);
            end
        end
        prev_done = rst_n && done;
    end

    // Driver: load table, push expectations, launch and await the job.
    task automatic run_job(int n, int iters, int a, int b, bit inject);
        int r0;
        int d0;
        for (int k = 0; k < n; k++) begin
            perm_m[k] = (a * k + b) % n;
            tbl_we  = 1'b1;
            tbl_idx = ADDR_W'(k);
            tbl_val = ADDR_W'(perm_m[k]);
            @(negedge clk);
        end
        tbl_we = 1'b0;
        for (int k = 0; k < n; k++) model[k] = 8'd0;
        for (int it = 0; it < iters; it++) begin
            for (int ph = 0; ph < 2; ph++) begin
                for (int k = 0; k < n; k++) begin
                    exp_t e;
                    int addr;
                    addr   = (ph == 1) ? perm_m[k] : k;
                    e.idx  = k;
                    e.ph   = ph;
                    e.apri = int'(model[addr]);
                    e.tag  = (it == 0) ? ((ph == 0) ? 2 : 5) : ((ph == 0) ? 4 : 6);
                    q.push_back(e);
                    model[addr] = model[addr] + 8'(k + 1);
                end
            end
        end
        r0 = req_cnt;
        d0 = done_cnt;
        start    = 1'b1;
        blk_len  = (ADDR_W+1)'(n);
        iter_num = ITER_W'(iters);
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            repeat (6) @(negedge clk);
            // R9: restart attempt with other settings while busy
            start    = 1'b1;
            blk_len  = (ADDR_W+1)'(3);
            iter_num = ITER_W'(1);
            @(negedge clk);
            start = 1'b0;
            // R9: table rewrite while busy
            for (int k = 0; k < n; k++) begin
                tbl_we  = 1'b1;
                tbl_idx = ADDR_W'(k);
                tbl_val = ADDR_W'(n - 1 - k);
                @(negedge clk);
            end
            tbl_we = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(req_cnt - r0 == 2 * n * iters, inject ? "R9 request count" : "R3 request count",
            req_cnt - r0, 2 * n * iters);
        chk(done_cnt - d0 == 1, "R8 single done", done_cnt - d0, 1);
        q.delete();
    endtask

    initial begin
        for (int i = 0; i <= LAT; i++) begin
            pv[i] = 1'b0;
            pd[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        chk(siso_req == 1'b0, "R1 req after reset", int'(siso_req), 0);
        repeat (3) @(negedge clk);
        chk(siso_req == 1'b0, "R1 req idle", int'(siso_req), 0);
        run_job(16, 2, 5, 3, 1'b0);
        run_job(5, 1, 2, 1, 1'b0);
        run_job(1, 3, 1, 0, 1'b0);
        // R8: zero iterations
        run_job(4, 0, 1, 1, 1'b0);
        run_job(8, 2, 3, 2, 1'b1);
        run_job(12, 3, 5, 7, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule